// File: doc/BRIEF.md
# Local Bus Bridge Cycle Generator

This block turns a single access request from a host-side bus into one cycle on an external 8-bit or 16-bit local bus. The request brings a write flag, a dword address, four active-low byte enables and 32 bits of write data. The block turns the byte enables into the two low address bits and an active-low byte-high enable. It then drives address, data and strobes for the programmed length. When the cycle ends it returns read data together with a one-clock done pulse.

Configuration inputs select several behaviours. One input picks the bus width. Another picks the strobe style: separate read and write strobes, or a read/write level with one data strobe. A 4-bit length code selects a fixed cycle length or a cycle that ends on an external ready input. A further input decides whether the block first gets bus ownership through a hold request and acknowledge handshake. All of these are captured when a request is accepted, so they may change while a cycle is running.

Top module: `lbus_cycle_gen`

## Requirements
- R1: On the 8-bit bus, the enabled byte with the lowest index sets the address low bits: be_n 1110 gives A1A0 00, 1101 gives 01, 1011 gives 10 and 0111 gives 11. The byte-high enable stays 1 in all four cases. The upper address bits carry the request address.
- R2: On the 16-bit bus, the half that holds the lowest enabled byte sets A1 (0 for bytes 0/1, 1 for bytes 2/3). A0 is 1 only when the lower byte of that half is disabled. The byte-high enable is 0 exactly when the upper byte of that half is enabled, so an upper-byte-only write uses A0 = 1 and byte-high = 0.
- R3: Write data goes out on the active lanes. On the 8-bit bus the selected byte is on bits 7:0. On the 16-bit bus the lower byte of the half is on 7:0 and the upper byte on 15:8. Inactive lanes read zero, and data output enable is high only while a write cycle drives the bus.
- R4: Read data is taken from the bus at the end of the cycle and returned in the host byte lanes it belongs to. All other lanes are zero.
- R5: A length code N from 1 to 11 keeps the strobe active for exactly N clocks. Done rises in the clock after the last strobe clock.
- R6: Length code 0000 keeps the strobe active until the active-low ready input is sampled low at a clock edge. That clock is the last strobe clock.
- R7: Length codes 1100 to 1111 are illegal. Such a cycle has a one-clock strobe, and the error output is high together with its done pulse and at no other time. Legal cycles never raise the error output.
- R8: Strobe style 0 pulses read strobe low for reads and write strobe low for writes. The data strobe stays high and the read/write line stays 1.
- R9: Strobe style 1 pulses the data strobe low. The read/write line is 1 for reads and 0 for writes during the cycle, and both separate strobes stay high.
- R10: With arbitration on, hold is raised after acceptance. Address, data and strobes stay undriven until acknowledge is sampled high. Hold drops in the done clock.
- R11: A request that arrives while a cycle is running is ignored: no second cycle follows, and the address bus does not change during the running cycle.
- R12: Done is a single-clock pulse, and read data is valid while done is high.
- R13: During reset and after it, the bus is idle: strobes and byte-high are inactive, the read/write line is 1, hold, both output enables, done and error are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock (one local bus clock) |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request, taken when idle |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | LB_AW-2 | Dword address |
| req_be_n_i | input | 4 | Byte enables, active low |
| req_wdata_i | input | 32 | Write data |
| cfg_wide_i | input | 1 | 0 = 8-bit bus, 1 = 16-bit bus |
| cfg_strobe_mode_i | input | 1 | 0 = read/write strobes, 1 = read/write level plus data strobe |
| cfg_cyc_len_i | input | 4 | Cycle length code |
| cfg_arb_en_i | input | 1 | Request bus ownership before driving |
| done_o | output | 1 | Cycle complete pulse |
| err_o | output | 1 | Illegal length code, with done |
| rdata_o | output | 32 | Read data in host lanes |
| lb_addr_o | output | LB_AW | Local address |
| lb_addr_oe_o | output | 1 | Address and strobe drive enable |
| lb_bhe_n_o | output | 1 | Byte-high enable, active low |
| lb_data_o | output | 16 | Local write data |
| lb_data_oe_o | output | 1 | Data drive enable |
| lb_data_i | input | 16 | Local read data |
| lb_rd_n_o | output | 1 | Read strobe, active low |
| lb_wr_n_o | output | 1 | Write strobe, active low |
| lb_rw_o | output | 1 | Read/write level, 1 = read |
| lb_ds_n_o | output | 1 | Data strobe, active low |
| lb_rdy_n_i | input | 1 | Ready, active low |
| lb_hold_o | output | 1 | Bus hold request |
| lb_hlda_i | input | 1 | Bus hold acknowledge |

## Verification
The vector table covers each single-byte enable on both bus widths, word-wide halves and upper-byte-only accesses. Together these separate a wrong lane choice from a wrong A0 or byte-high decode. It uses several fixed lengths, including 1 and 11, which catch off-by-one errors in the length counter, and two illegal codes, which show the one-clock error path. Each strobe style is run with both reads and writes, so a swapped strobe or an inverted read/write level shows up. Directed runs cover the ready-ended cycle, a grant withheld for several clocks, and a second request during a busy cycle.

// File: rtl/lbus_pkg.sv
package lbus_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ARB  = 2'd1,
    ST_ACT  = 2'd2,
    ST_END  = 2'd3
  } lb_state_e;

  localparam logic [3:0] LEN_READY = 4'd0;
endpackage

// File: rtl/lbus_lane_map.sv
module lbus_lane_map #(
  parameter int HOST_DW = 32,
  parameter int LB_DW   = 16
) (
  input  logic                 wide_i,
  input  logic [HOST_DW/8-1:0] be_n_i,
  input  logic [HOST_DW-1:0]   wdata_i,
  input  logic [LB_DW-1:0]     bus_rdata_i,
  output logic [1:0]           a_lo_o,
  output logic                 bhe_n_o,
  output logic [LB_DW-1:0]     bus_wdata_o,
  output logic [HOST_DW-1:0]   host_rdata_o
);
  localparam int NB = HOST_DW / 8;
  localparam int SW = $clog2(NB);

  logic [SW-1:0] sel;
  logic [SW-1:0] lo_idx;
  logic [SW-1:0] hi_idx;
  logic          lo_en;
  logic          hi_en;

  // lowest enabled byte wins
  always_comb begin
    sel = '0;
    for (int i = NB - 1; i >= 0; i--) begin
      if (!be_n_i[i]) sel = SW'(i);
    end
  end

  assign lo_idx = {sel[SW-1:1], 1'b0};
  assign hi_idx = {sel[SW-1:1], 1'b1};
  assign lo_en  = ~be_n_i[lo_idx];
  assign hi_en  = ~be_n_i[hi_idx];

  always_comb begin
    host_rdata_o = '0;
    bus_wdata_o  = '0;
    if (!wide_i) begin
      a_lo_o  = sel[1:0];
      bhe_n_o = 1'b1;
      bus_wdata_o[7:0] = wdata_i[{sel, 3'b000} +: 8];
      host_rdata_o[{sel, 3'b000} +: 8] = bus_rdata_i[7:0];
    end else begin
      a_lo_o  = {sel[1], ~lo_en};
      bhe_n_o = ~hi_en;
      if (lo_en) begin
        bus_wdata_o[7:0] = wdata_i[{lo_idx, 3'b000} +: 8];
        host_rdata_o[{lo_idx, 3'b000} +: 8] = bus_rdata_i[7:0];
      end
      if (hi_en) begin
        bus_wdata_o[15:8] = wdata_i[{hi_idx, 3'b000} +: 8];
        host_rdata_o[{hi_idx, 3'b000} +: 8] = bus_rdata_i[15:8];
      end
    end
  end
endmodule

// File: rtl/lbus_len_timer.sv
module lbus_len_timer #(
  parameter int LEN_W   = 4,
  parameter int LEN_MAX = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             run_i,
  input  logic             rdy_n_i,
  output logic             expire_o,
  output logic             illegal_o
);
  logic [LEN_W-1:0] cnt_q;
  logic             rdy_mode_q;
  logic             illegal_q;
  logic             len_bad;

  assign len_bad = (len_i > LEN_W'(LEN_MAX));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q      <= '0;
      rdy_mode_q <= 1'b0;
      illegal_q  <= 1'b0;
    end else if (load_i) begin
      rdy_mode_q <= (len_i == '0);
      illegal_q  <= len_bad;
      cnt_q      <= (len_i == '0 || len_bad) ? '0 : len_i - 1'b1;
    end else if (run_i && cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expire_o  = run_i & (rdy_mode_q ? ~rdy_n_i : (cnt_q == '0));
  assign illegal_o = illegal_q;

  AST_ILLEGAL_ONE_CLK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i && illegal_q |-> expire_o); // R7
  AST_CNT_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i && !rdy_mode_q |-> cnt_q < LEN_W'(LEN_MAX)); // R5
endmodule

// File: rtl/lbus_strobe_gen.sv
module lbus_strobe_gen (
  input  logic mode_i,
  input  logic write_i,
  input  logic active_i,
  output logic rd_n_o,
  output logic wr_n_o,
  output logic rw_o,
  output logic ds_n_o
);
  assign rd_n_o = ~(active_i & ~mode_i & ~write_i);
  assign wr_n_o = ~(active_i & ~mode_i &  write_i);
  assign ds_n_o = ~(active_i &  mode_i);
  assign rw_o   = ~(active_i &  mode_i &  write_i);

  always_comb begin
    AST_STROBE_MUTEX: assert (rd_n_o || wr_n_o); // R8
    AST_ONE_STYLE: assert (ds_n_o || (rd_n_o && wr_n_o)); // R9
  end
endmodule

// File: rtl/lbus_cycle_gen.sv
module lbus_cycle_gen
  import lbus_pkg::*;
#(
  parameter int LB_AW   = 20,
  parameter int HOST_DW = 32,
  parameter int LB_DW   = 16,
  parameter int LEN_W   = 4,
  parameter int LEN_MAX = 11,
  localparam int HA_W   = LB_AW - 2,
  localparam int NB     = HOST_DW / 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_i,
  input  logic               req_write_i,
  input  logic [HA_W-1:0]    req_addr_i,
  input  logic [NB-1:0]      req_be_n_i,
  input  logic [HOST_DW-1:0] req_wdata_i,
  input  logic               cfg_wide_i,
  input  logic               cfg_strobe_mode_i,
  input  logic [LEN_W-1:0]   cfg_cyc_len_i,
  input  logic               cfg_arb_en_i,
  output logic               done_o,
  output logic               err_o,
  output logic [HOST_DW-1:0] rdata_o,
  output logic [LB_AW-1:0]   lb_addr_o,
  output logic               lb_addr_oe_o,
  output logic               lb_bhe_n_o,
  output logic [LB_DW-1:0]   lb_data_o,
  output logic               lb_data_oe_o,
  input  logic [LB_DW-1:0]   lb_data_i,
  output logic               lb_rd_n_o,
  output logic               lb_wr_n_o,
  output logic               lb_rw_o,
  output logic               lb_ds_n_o,
  input  logic               lb_rdy_n_i,
  output logic               lb_hold_o,
  input  logic               lb_hlda_i
);
  lb_state_e state_q, state_d;

  logic               accept;
  logic               active;
  logic               expire;
  logic               illegal;
  logic               write_q;
  logic               wide_q;
  logic               mode_q;
  logic               arb_q;
  logic [HA_W-1:0]    addr_q;
  logic [NB-1:0]      be_n_q;
  logic [HOST_DW-1:0] wdata_q;
  logic [HOST_DW-1:0] rdata_q;
  logic [HOST_DW-1:0] host_rdata;
  logic [1:0]         a_lo;
  logic               bhe_n;

  assign accept = (state_q == ST_IDLE) && req_i;
  assign active = (state_q == ST_ACT);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (req_i) state_d = cfg_arb_en_i ? ST_ARB : ST_ACT;
      ST_ARB:  if (lb_hlda_i) state_d = ST_ACT;
      ST_ACT:  if (expire) state_d = ST_END;
      ST_END:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      write_q <= 1'b0;
      wide_q  <= 1'b0;
      mode_q  <= 1'b0;
      arb_q   <= 1'b0;
      addr_q  <= '0;
      be_n_q  <= '1;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        write_q <= req_write_i;
        wide_q  <= cfg_wide_i;
        mode_q  <= cfg_strobe_mode_i;
        arb_q   <= cfg_arb_en_i;
        addr_q  <= req_addr_i;
        be_n_q  <= req_be_n_i;
        wdata_q <= req_wdata_i;
      end
      if (active && expire && !write_q) rdata_q <= host_rdata;
    end
  end

  lbus_lane_map #(
    .HOST_DW(HOST_DW),
    .LB_DW  (LB_DW)
  ) u_lane_map (
    .wide_i      (wide_q),
    .be_n_i      (be_n_q),
    .wdata_i     (wdata_q),
    .bus_rdata_i (lb_data_i),
    .a_lo_o      (a_lo),
    .bhe_n_o     (bhe_n),
    .bus_wdata_o (lb_data_o),
    .host_rdata_o(host_rdata)
  );

  lbus_len_timer #(
    .LEN_W  (LEN_W),
    .LEN_MAX(LEN_MAX)
  ) u_len_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (accept),
    .len_i    (cfg_cyc_len_i),
    .run_i    (active),
    .rdy_n_i  (lb_rdy_n_i),
    .expire_o (expire),
    .illegal_o(illegal)
  );

  lbus_strobe_gen u_strobe_gen (
    .mode_i  (mode_q),
    .write_i (write_q),
    .active_i(active),
    .rd_n_o  (lb_rd_n_o),
    .wr_n_o  (lb_wr_n_o),
    .rw_o    (lb_rw_o),
    .ds_n_o  (lb_ds_n_o)
  );

  assign lb_addr_o    = {addr_q, a_lo};
  assign lb_bhe_n_o   = bhe_n | ~active;
  assign lb_addr_oe_o = active;
  assign lb_data_oe_o = active & write_q;
  assign lb_hold_o    = arb_q & ((state_q == ST_ARB) | active);
  assign done_o       = (state_q == ST_END);
  assign err_o        = done_o & illegal;
  assign rdata_o      = rdata_q;

  AST_GRANT_BEFORE_DRIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lb_addr_oe_o) && arb_q |-> $past(lb_hlda_i)); // R10
  AST_NO_DRIVE_WHILE_WAIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lb_hold_o && !lb_addr_oe_o |-> lb_rd_n_o && lb_wr_n_o && lb_ds_n_o && !lb_data_oe_o); // R10
  AST_BHE_8BIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lb_addr_oe_o && !wide_q |-> lb_bhe_n_o); // R1
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R12
  AST_ERR_WITH_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> done_o); // R7
  AST_ADDR_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lb_addr_oe_o && $past(lb_addr_oe_o) |-> $stable(lb_addr_o)); // R11
  AST_DONE_AFTER_DRIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(lb_addr_oe_o)); // R5
endmodule

// File: tb/lbus_cycle_gen_bench.sv
module lbus_cycle_gen_bench;
  localparam int CLK_PERIOD = 10;
  localparam int LB_AW = 20;
  localparam int HA_W  = LB_AW - 2;

  typedef struct packed {
    logic        wr;
    logic [3:0]  be_n;
    logic        wide;
    logic        smode;
    logic [3:0]  len;
    logic [1:0]  ea;
    logic        ebhe;
    logic [15:0] edout;
    logic [31:0] erd;
    logic        eerr;
    logic [4:0]  eclk;
  } vec_t;

  // wdata A1B2C3D4, bus read data 5E6F
  localparam vec_t VECS [12] = '{
    '{1'b1, 4'b1110, 1'b0, 1'b0, 4'd4,  2'b00, 1'b1, 16'h00D4, 32'h0,        1'b0, 5'd4},
    '{1'b1, 4'b1101, 1'b0, 1'b0, 4'd1,  2'b01, 1'b1, 16'h00C3, 32'h0,        1'b0, 5'd1},
    '{1'b0, 4'b1011, 1'b0, 1'b1, 4'd2,  2'b10, 1'b1, 16'h0,    32'h006F0000, 1'b0, 5'd2},
    '{1'b0, 4'b0111, 1'b0, 1'b1, 4'd11, 2'b11, 1'b1, 16'h0,    32'h6F000000, 1'b0, 5'd11},
    '{1'b1, 4'b1100, 1'b1, 1'b0, 4'd3,  2'b00, 1'b0, 16'hC3D4, 32'h0,        1'b0, 5'd3},
    '{1'b1, 4'b0011, 1'b1, 1'b1, 4'd5,  2'b10, 1'b0, 16'hA1B2, 32'h0,        1'b0, 5'd5},
    '{1'b1, 4'b1101, 1'b1, 1'b0, 4'd2,  2'b01, 1'b0, 16'hC300, 32'h0,        1'b0, 5'd2},
    '{1'b0, 4'b0011, 1'b1, 1'b0, 4'd6,  2'b10, 1'b0, 16'h0,    32'h5E6F0000, 1'b0, 5'd6},
    '{1'b0, 4'b1110, 1'b1, 1'b1, 4'd1,  2'b00, 1'b1, 16'h0,    32'h0000006F, 1'b0, 5'd1},
    '{1'b1, 4'b0111, 1'b1, 1'b0, 4'd4,  2'b11, 1'b0, 16'hA100, 32'h0,        1'b0, 5'd4},
    '{1'b0, 4'b1110, 1'b0, 1'b0, 4'd13, 2'b00, 1'b1, 16'h0,    32'h0000006F, 1'b1, 5'd1},
    '{1'b1, 4'b1011, 1'b1, 1'b1, 4'd15, 2'b10, 1'b1, 16'h00B2, 32'h0,        1'b1, 5'd1}
  };

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req = 1'b0;
  logic        req_write = 1'b0;
  logic [HA_W-1:0] req_addr = '0;
  logic [3:0]  req_be_n = 4'hF;
  logic [31:0] req_wdata = 32'hA1B2C3D4;
  logic        cfg_wide = 1'b0;
  logic        cfg_smode = 1'b0;
  logic [3:0]  cfg_len = 4'd1;
  logic        cfg_arb = 1'b0;
  logic        done, err;
  logic [31:0] rdata;
  logic [LB_AW-1:0] lb_addr;
  logic        addr_oe, bhe_n, data_oe, rd_n, wr_n, rw, ds_n, hold;
  logic [15:0] lb_dout;
  logic [15:0] lb_din = 16'h5E6F;
  logic        rdy_n = 1'b1;
  logic        hlda = 1'b0;

  int checks = 0;
  int fails = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  lbus_cycle_gen #(.LB_AW(LB_AW)) u_lbus_cycle_gen (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req), .req_write_i(req_write),
    .req_addr_i(req_addr), .req_be_n_i(req_be_n), .req_wdata_i(req_wdata),
    .cfg_wide_i(cfg_wide), .cfg_strobe_mode_i(cfg_smode), .cfg_cyc_len_i(cfg_len),
    .cfg_arb_en_i(cfg_arb), .done_o(done), .err_o(err), .rdata_o(rdata),
    .lb_addr_o(lb_addr), .lb_addr_oe_o(addr_oe), .lb_bhe_n_o(bhe_n),
    .lb_data_o(lb_dout), .lb_data_oe_o(data_oe), .lb_data_i(lb_din),
    .lb_rd_n_o(rd_n), .lb_wr_n_o(wr_n), .lb_rw_o(rw), .lb_ds_n_o(ds_n),
    .lb_rdy_n_i(rdy_n), .lb_hold_o(hold), .lb_hlda_i(hlda)
  );

  task automatic check(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic check_idle(input string rq);
    check(rd_n && wr_n && ds_n && rw && bhe_n, rq, {rd_n, wr_n, ds_n, rw, bhe_n}, 5'h1F);
    check(!hold && !addr_oe && !data_oe && !done && !err, rq,
          {hold, addr_oe, data_oe, done, err}, 0);
  endtask

  // one complete cycle; arb: grant after gdly clocks; rdy_after>0: ready ends it; poke: second req mid-cycle
  task automatic run_cycle(input vec_t v, input logic [HA_W-1:0] haddr, input bit arb,
                           input int gdly, input int rdy_after, input bit poke);
    int  clks = 0;
    bit  style_bad = 1'b0;
    bit  addr_bad = 1'b0;
    logic [LB_AW-1:0] a_seen = '0;
    logic             bhe_seen = 1'b1;
    logic [15:0]      d_seen = '0;
    logic             doe_seen = 1'b0;
    @(negedge clk);
    req_write = v.wr; req_be_n = v.be_n; cfg_wide = v.wide; cfg_smode = v.smode;
    cfg_len = v.len; cfg_arb = arb; req_addr = haddr; req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    if (arb) begin
      for (int k = 0; k < gdly; k++) begin
        check(hold && !addr_oe && !data_oe && rd_n && wr_n && ds_n, "R10 wait",
              {hold, addr_oe, data_oe, rd_n, wr_n, ds_n}, 6'b100111);
        @(negedge clk);
      end
      hlda = 1'b1;
      @(negedge clk);
    end
    for (int g = 0; g < 40; g++) begin
      bit act;
      act = v.smode ? !ds_n : (!rd_n || !wr_n);
      if (!act) break;
      clks++;
      if (clks == 1) begin
        a_seen = lb_addr; bhe_seen = bhe_n; d_seen = lb_dout; doe_seen = data_oe;
      end
      if (lb_addr != a_seen) addr_bad = 1'b1;
      if (!v.smode && !(ds_n && rw && (v.wr ? (!wr_n && rd_n) : (!rd_n && wr_n)))) style_bad = 1'b1;
      if (v.smode && !(rd_n && wr_n && (rw == !v.wr))) style_bad = 1'b1;
      if (poke && clks == 2) begin
        req = 1'b1; req_addr = ~haddr; req_write = ~v.wr;
      end else begin
        req = 1'b0;
      end
      if (rdy_after > 0 && clks == rdy_after) rdy_n = 1'b0;
      @(negedge clk);
    end
    req = 1'b0; rdy_n = 1'b1; hlda = 1'b0;
    check(clks == int'(v.eclk), v.eerr ? "R7 length" : (rdy_after > 0 ? "R6 length" : "R5 length"),
          clks, v.eclk);
    check(done, "R5 done after last strobe", done, 1);
    check(err == v.eerr, "R7 err flag", err, v.eerr);
    check(a_seen == {haddr, v.ea}, v.wide ? "R2 addr map" : "R1 addr map", a_seen, {haddr, v.ea});
    check(bhe_seen == v.ebhe, v.wide ? "R2 bhe" : "R1 bhe", bhe_seen, v.ebhe);
    check(!style_bad, v.smode ? "R9 strobe style" : "R8 strobe style", style_bad, 0);
    check(!addr_bad, "R11 addr stable", addr_bad, 0);
    check(doe_seen == v.wr, "R3 data oe", doe_seen, v.wr);
    if (v.wr) check(d_seen == v.edout, "R3 write lanes", d_seen, v.edout);
    else      check(rdata == v.erd, "R4/R12 read lanes", rdata, v.erd);
    if (arb) check(!hold, "R10 hold release", hold, 0);
    @(negedge clk);
    check(!done && !err, "R12 single pulse", {done, err}, 0);
    if (poke) begin
      for (int k = 0; k < 3; k++) begin
        check(!addr_oe && !done, "R11 no second cycle", {addr_oe, done}, 0);
        @(negedge clk);
      end
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    vec_t v;
    repeat (3) @(negedge clk);
    check_idle("R13 in reset");
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    check_idle("R13 after reset");

    foreach (VECS[i]) run_cycle(VECS[i], HA_W'(18'h2A5C0 + i), 1'b0, 0, 0, 1'b0);

    // R6: ready-terminated, 8-bit read, separate strobes
    v = '{1'b0, 4'b1101, 1'b0, 1'b0, 4'd0, 2'b01, 1'b1, 16'h0, 32'h00006F00, 1'b0, 5'd5};
    run_cycle(v, HA_W'(18'h01234), 1'b0, 0, 5, 1'b0);
    // R6 ready on first strobe clock, 16-bit write, data strobe style
    v = '{1'b1, 4'b1100, 1'b1, 1'b1, 4'd0, 2'b00, 1'b0, 16'hC3D4, 32'h0, 1'b0, 5'd1};
    run_cycle(v, HA_W'(18'h3FFFF), 1'b0, 0, 1, 1'b0);
    // R10: arbitration, grant after 4 clocks
    v = '{1'b1, 4'b1011, 1'b0, 1'b1, 4'd3, 2'b10, 1'b1, 16'h00B2, 32'h0, 1'b0, 5'd3};
    run_cycle(v, HA_W'(18'h00F0F), 1'b1, 4, 0, 1'b0);
    // R10 with immediate grant, ready-ended read
    v = '{1'b0, 4'b0011, 1'b1, 1'b0, 4'd0, 2'b10, 1'b0, 16'h0, 32'h5E6F0000, 1'b0, 5'd2};
    run_cycle(v, HA_W'(18'h10001), 1'b1, 1, 2, 1'b0);
    // R11: request during a running cycle
    v = '{1'b1, 4'b1110, 1'b0, 1'b0, 4'd6, 2'b00, 1'b1, 16'h00D4, 32'h0, 1'b0, 5'd6};
    run_cycle(v, HA_W'(18'h05555), 1'b0, 0, 0, 1'b1);

    check_idle("R13 idle at end");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule